// File: doc/BRIEF.md
# Input-Queued Cell Switch Scheduler

This block schedules an N x N switch for fixed-size cells where the buffering sits at the inputs. Every input owns a small queue of cells, and each cell is tagged with the output it wants. In every clock cycle, which is one time slot, the block resolves output conflicts before any cell crosses the fabric. Each output receives at most one cell and each input sends at most one. The granted cells appear on a per-output bus for that one cycle. A cell that loses stays in its queue and competes again in the following slot.

The inputs that want the same output are resolved by a per-output pseudo-random arbiter. Each arbiter is seeded from a parameter, so a run can be repeated exactly. A mode input sets the queue discipline. With lookahead off, only head cells may leave, so a blocked head holds back the cells queued behind it. With lookahead on, matching runs in rounds. In round k, every input that is still unmatched offers its k-th cell to the outputs that are still free, for up to W rounds. A cell taken from the middle of a queue is removed by shifting the younger cells forward. An arrival at a full queue is discarded and reported with a one-cycle pulse. Per-output counters record departures so that throughput can be measured.

Top module: `isw_sched`

## Requirements
- R1: After reset, every out_valid bit is 0, every q_full and drop_pulse bit is 0, and every dep_count field is 0.
- R2: A cell presented on in_valid/in_dest/in_data is captured at a clock edge. If it is granted in the next slot, its output shows out_valid=1 one edge later, with out_src equal to the input index and out_data equal to the cell's data. An output with no grant shows out_valid=0.
- R3: Within one slot, no input index appears on two valid outputs.
- R4: Inputs that lose contention keep their cells, and every accepted cell eventually departs once arrivals stop.
- R5: When several inputs contend for one output, the winner is chosen by a per-output LFSR whose seed is a parameter. Over repeated contention, each contender wins a share of the slots.
- R6: With lookahead_en=0, only the cell at queue position 0 (the oldest) of an input may depart.
- R7: With lookahead_en=1, a departing cell sits at a queue position below W.
- R8: An output left idle in a slot has no unmatched input holding an offerable cell for it. With lookahead off, an offerable cell is the head. With lookahead on, it is any of the first W cells.
- R9: The cells of one input that go to the same output depart in their arrival order. Removing a cell from the middle of a queue keeps the order of the cells that remain.
- R10: q_full[i] is 1 exactly when input i holds DEPTH cells. An arrival while the queue is full at the start of the cycle is discarded, drop_pulse[i] is 1 for one cycle one edge later, and the queue contents do not change from that arrival.
- R11: dep_count[o] (CNT_W bits, field o) increases by one for each cycle in which out_valid[o] is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| lookahead_en | input | 1 | 1 enables windowed offers beyond the head cell |
| in_valid | input | N | Per-input arrival strobe |
| in_dest | input | N*SW | Destination output of each arrival, field i at bits i*SW |
| in_data | input | N*DW | Cell data of each arrival, field i at bits i*DW |
| q_full | output | N | Input queue holds DEPTH cells |
| drop_pulse | output | N | One-cycle pulse for a discarded arrival |
| out_valid | output | N | Output carries a granted cell this cycle |
| out_src | output | N*SW | Source input index per output |
| out_data | output | N*DW | Cell data per output |
| dep_count | output | N*CNT_W | Per-output departure counter |

## Verification
The bench keeps a queue model per input and checks every departure against it. Each departing cell must exist at the granted input. It must sit at the head or inside the window, and it must be the oldest cell of that input for that output. A design that compacted its queues wrongly would send a cell that was duplicated or lost. A design that ignored the mode would let a cell behind the head leave while lookahead is off. Idle outputs are checked against unmatched inputs that still hold offerable cells, which catches a matcher that stops after one round or skips free outputs. A sustained two-way hot spot fills the queues to test drops and full flags and to confirm that both contenders win, so an arbiter with a fixed priority or a drop judged one cell late is exposed.

// File: rtl/isw_pkg.sv
package isw_pkg;
  localparam int LFSR_W = 8;
  localparam logic [LFSR_W-1:0] LFSR_TAPS = 8'hB8;

  // Galois step, maximal length for x^8+x^6+x^5+x^4+1
  function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] s);
    return {1'b0, s[LFSR_W-1:1]} ^ (s[0] ? LFSR_TAPS : '0);
  endfunction

  // (base + off) mod n for base, off below n
  function automatic int wrap_idx(input int base, input int off, input int n);
    int v;
    v = base + off;
    if (v >= n) v = v - n;
    return v;
  endfunction
endpackage

// File: rtl/isw_in_queue.sv
module isw_in_queue #(
  parameter int DEPTH  = 8,
  parameter int CELL_W = 18,
  parameter int IW     = 3,
  parameter int CNTW   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [CELL_W-1:0] push_cell,
  input  logic              pop,
  input  logic [IW-1:0]     pop_idx,
  output logic [CELL_W-1:0] ent [DEPTH],
  output logic [CNTW-1:0]   cnt,
  output logic              full,
  output logic              drop
);
  logic [CELL_W-1:0] ent_q [DEPTH];
  logic [CELL_W-1:0] ent_d [DEPTH];
  logic [CNTW-1:0]   cnt_q, cnt_d, base;
  logic              drop_q, drop_d;

  assign full = (cnt_q == CNTW'(DEPTH));

  // next state: compact out the popped entry, then append behind the survivors
  always_comb begin
    ent_d = ent_q;
    base  = cnt_q;
    if (pop) begin
      for (int j = 0; j < DEPTH - 1; j++) begin
        if (j >= int'(pop_idx)) ent_d[j] = ent_q[j+1];
      end
      base = cnt_q - CNTW'(1);
    end
    drop_d = push && full;
    cnt_d  = base;
    if (push && !full) begin
      for (int j = 0; j < DEPTH; j++) begin
        if (j == int'(base)) ent_d[j] = push_cell;
      end
      cnt_d = base + CNTW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (push || pop) ent_q <= ent_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      drop_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      drop_q <= drop_d;
    end
  end

  assign ent  = ent_q;
  assign cnt  = cnt_q;
  assign drop = drop_q;

  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt_q) <= DEPTH) else $error("queue count above depth");

  assert_pop_in_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (int'(pop_idx) < int'(cnt_q))) else $error("pop beyond occupancy");

  assert_drop_keeps_count_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> (cnt_q == $past(cnt_q) && drop_q)) else $error("full arrival changed queue");
endmodule

// File: rtl/isw_lfsr.sv
module isw_lfsr
  import isw_pkg::*;
#(
  parameter int                N    = 4,
  parameter int                SW   = 2,
  parameter logic [LFSR_W-1:0] SEED = 8'h5A
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [SW-1:0] start
);
  localparam logic [LFSR_W-1:0] SEED_NZ = (SEED == '0) ? LFSR_W'(1) : SEED;

  logic [LFSR_W-1:0] st_q, st_d;

  always_comb st_d = lfsr_step(st_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= SEED_NZ;
    else        st_q <= st_d;
  end

  assign start = SW'(int'(st_q) % N);

  assert_lfsr_alive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    st_q != '0) else $error("arbiter LFSR stuck at zero");
endmodule

// File: rtl/isw_matcher.sv
module isw_matcher
  import isw_pkg::*;
#(
  parameter int N    = 4,
  parameter int W    = 8,
  parameter int SW   = 2,
  parameter int IW   = 3,
  parameter int CNTW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            la_en,
  input  logic [CNTW-1:0] cnt      [N],
  input  logic [SW-1:0]   win_dest [N][W],
  input  logic [SW-1:0]   start    [N],
  output logic [N-1:0]    in_go,
  output logic [IW-1:0]   in_pick  [N],
  output logic [N-1:0]    out_go,
  output logic [SW-1:0]   out_src  [N]
);
  // round k: every unmatched input offers its k-th cell to a still-free output;
  // each output scans requesters from its own pseudo-random start index
  always_comb begin
    in_go  = '0;
    out_go = '0;
    for (int i = 0; i < N; i++) begin
      in_pick[i] = '0;
      out_src[i] = '0;
    end
    for (int k = 0; k < W; k++) begin
      if (k == 0 || la_en) begin
        for (int o = 0; o < N; o++) begin
          for (int r = 0; r < N; r++) begin
            if (!out_go[o]
                && !in_go[wrap_idx(int'(start[o]), r, N)]
                && int'(cnt[wrap_idx(int'(start[o]), r, N)]) > k
                && win_dest[wrap_idx(int'(start[o]), r, N)][k] == SW'(o)) begin
              out_go[o] = 1'b1;
              out_src[o] = SW'(wrap_idx(int'(start[o]), r, N));
              in_go[wrap_idx(int'(start[o]), r, N)] = 1'b1;
              in_pick[wrap_idx(int'(start[o]), r, N)] = IW'(k);
            end
          end
        end
      end
    end
  end

  for (genvar gi = 0; gi < N; gi++) begin : g_chk
    assert_head_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!la_en && in_go[gi]) |-> (in_pick[gi] == '0)) else $error("non-head pick with lookahead off");
    assert_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
      in_go[gi] |-> (int'(in_pick[gi]) < W && int'(in_pick[gi]) < int'(cnt[gi]))) else $error("pick outside window");
  end
endmodule

// File: rtl/isw_sched.sv
module isw_sched
  import isw_pkg::*;
#(
  parameter int                N     = 4,
  parameter int                DEPTH = 8,
  parameter int                W     = 8,
  parameter int                DW    = 16,
  parameter int                CNT_W = 16,
  parameter logic [LFSR_W-1:0] SEED  = 8'h5A,
  localparam int               SW    = $clog2(N)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               lookahead_en,
  input  logic [N-1:0]       in_valid,
  input  logic [N*SW-1:0]    in_dest,
  input  logic [N*DW-1:0]    in_data,
  output logic [N-1:0]       q_full,
  output logic [N-1:0]       drop_pulse,
  output logic [N-1:0]       out_valid,
  output logic [N*SW-1:0]    out_src,
  output logic [N*DW-1:0]    out_data,
  output logic [N*CNT_W-1:0] dep_count
);
  localparam int IW     = $clog2(DEPTH);
  localparam int CNTW   = $clog2(DEPTH + 1);
  localparam int CELL_W = SW + DW;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rs_q;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i_n = rs_q[1];

  logic [CELL_W-1:0] q_ent    [N][DEPTH];
  logic [CNTW-1:0]   q_cnt    [N];
  logic [SW-1:0]     win_dest [N][W];
  logic [SW-1:0]     arb_start[N];
  logic [N-1:0]      in_go, out_go;
  logic [IW-1:0]     in_pick  [N];
  logic [SW-1:0]     out_src_c[N];

  for (genvar gi = 0; gi < N; gi++) begin : g_in
    isw_in_queue #(.DEPTH(DEPTH), .CELL_W(CELL_W), .IW(IW), .CNTW(CNTW)) u_q (
      .clk       (clk),
      .rst_n     (rst_i_n),
      .push      (in_valid[gi]),
      .push_cell ({in_dest[gi*SW +: SW], in_data[gi*DW +: DW]}),
      .pop       (in_go[gi]),
      .pop_idx   (in_pick[gi]),
      .ent       (q_ent[gi]),
      .cnt       (q_cnt[gi]),
      .full      (q_full[gi]),
      .drop      (drop_pulse[gi])
    );
    for (genvar gk = 0; gk < W; gk++) begin : g_win
      assign win_dest[gi][gk] = q_ent[gi][gk][CELL_W-1:DW];
    end
  end

  for (genvar go = 0; go < N; go++) begin : g_arb
    isw_lfsr #(.N(N), .SW(SW), .SEED(SEED ^ LFSR_W'(37 * go))) u_lfsr (
      .clk   (clk),
      .rst_n (rst_i_n),
      .start (arb_start[go])
    );
  end

  isw_matcher #(.N(N), .W(W), .SW(SW), .IW(IW), .CNTW(CNTW)) u_match (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .la_en    (lookahead_en),
    .cnt      (q_cnt),
    .win_dest (win_dest),
    .start    (arb_start),
    .in_go    (in_go),
    .in_pick  (in_pick),
    .out_go   (out_go),
    .out_src  (out_src_c)
  );

  // crossbar select and output registers
  logic [CELL_W-1:0] out_cell_d [N];
  logic [N-1:0]      ov_q;
  logic [SW-1:0]     os_q [N];
  logic [DW-1:0]     od_q [N];
  logic [CNT_W-1:0]  dc_q [N];
  logic [CNT_W-1:0]  dc_d [N];

  always_comb begin
    for (int o = 0; o < N; o++) begin
      out_cell_d[o] = q_ent[out_src_c[o]][in_pick[out_src_c[o]]];
      dc_d[o]       = dc_q[o] + CNT_W'(out_go[o]);
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      ov_q <= '0;
      for (int o = 0; o < N; o++) dc_q[o] <= '0;
    end else begin
      ov_q <= out_go;
      for (int o = 0; o < N; o++) dc_q[o] <= dc_d[o];
    end
  end

  always_ff @(posedge clk) begin
    for (int o = 0; o < N; o++) begin
      if (out_go[o]) begin
        os_q[o] <= out_src_c[o];
        od_q[o] <= out_cell_d[o][DW-1:0];
      end
    end
  end

  for (genvar go = 0; go < N; go++) begin : g_out
    assign out_valid[go]                = ov_q[go];
    assign out_src[go*SW +: SW]         = os_q[go];
    assign out_data[go*DW +: DW]        = od_q[go];
    assign dep_count[go*CNT_W +: CNT_W] = dc_q[go];

    assert_count_step_R11: assert property (@(posedge clk) disable iff (!rst_i_n)
      dc_q[go] == $past(dc_q[go]) + CNT_W'(ov_q[go])) else $error("departure counter step");

    for (genvar gp = go + 1; gp < N; gp++) begin : g_pair
      assert_single_input_grant_R3: assert property (@(posedge clk) disable iff (!rst_i_n)
        !(ov_q[go] && ov_q[gp] && os_q[go] == os_q[gp])) else $error("input granted twice");
    end
  end
endmodule

// File: tb/isw_sched_tb.sv
module isw_sched_tb;
  localparam int N = 4, DEPTH = 8, W = 4, DW = 16, CNT_W = 16;
  localparam int SW = $clog2(N);
  localparam int CELL_W = SW + DW;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic               rst_n, la_en;
  logic [N-1:0]       in_valid;
  logic [N*SW-1:0]    in_dest;
  logic [N*DW-1:0]    in_data;
  logic [N-1:0]       q_full, drop_pulse, out_valid;
  logic [N*SW-1:0]    out_src;
  logic [N*DW-1:0]    out_data;
  logic [N*CNT_W-1:0] dep_count;

  isw_sched #(.N(N), .DEPTH(DEPTH), .W(W), .DW(DW), .CNT_W(CNT_W), .SEED(8'h5A)) u_dut (
    .clk(clk), .rst_n(rst_n), .lookahead_en(la_en), .in_valid(in_valid), .in_dest(in_dest),
    .in_data(in_data), .q_full(q_full), .drop_pulse(drop_pulse), .out_valid(out_valid),
    .out_src(out_src), .out_data(out_data), .dep_count(dep_count));

  int checks = 0, fails = 0;
  logic [CELL_W-1:0] mq [N][DEPTH];   // scoreboard: expected queue per input
  int mcnt [N];
  int tally [N];
  int seq [N];
  int wins [N];
  int drops = 0, accepted = 0;

  function automatic int imin(int a, int b);
    return (a < b) ? a : b;
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // driver: place one arrival on input i for the coming edge
  task automatic set_in(int i, int d);
    in_valid[i] = 1'b1;
    in_dest[i*SW +: SW] = SW'(d);
    in_data[i*DW +: DW] = {4'(i), 12'(seq[i])};
    seq[i]++;
  endtask

  // one slot: capture stimulus, cross the edge, monitor outputs against the model
  task automatic tick();
    logic [N-1:0]      a_v;
    logic [CELL_W-1:0] a_c [N];
    logic [N-1:0]      used;
    bit                gone [N][DEPTH];
    bit                was_la;
    was_la = la_en;
    a_v = in_valid;
    for (int i = 0; i < N; i++) a_c[i] = {in_dest[i*SW +: SW], in_data[i*DW +: DW]};
    @(posedge clk);
    #2;
    in_valid = '0;
    used = '0;
    for (int i = 0; i < N; i++) for (int j = 0; j < DEPTH; j++) gone[i][j] = 1'b0;
    for (int o = 0; o < N; o++) begin
      if (out_valid[o]) begin
        int s, p, first;
        s = int'(out_src[o*SW +: SW]);
        p = -1;
        first = -1;
        for (int j = 0; j < mcnt[s]; j++) begin
          if (p < 0 && mq[s][j][DW-1:0] == out_data[o*DW +: DW]) p = j;
          if (first < 0 && int'(mq[s][j][CELL_W-1:DW]) == o) first = j;
        end
        chk(p >= 0, "R2", "departing cell held at granted input", p, 0);
        if (p >= 0) begin
          chk(int'(mq[s][p][CELL_W-1:DW]) == o, "R2", "cell destination", int'(mq[s][p][CELL_W-1:DW]), o);
          if (was_la) chk(p < W, "R7", "queue position inside window", p, W - 1);
          else        chk(p == 0, "R6", "queue position with lookahead off", p, 0);
          chk(first == p, "R9", "oldest cell for this output", p, first);
          gone[s][p] = 1'b1;
        end
        chk(!used[s], "R3", "input granted on two outputs", 1, 0);
        used[s] = 1'b1;
        tally[o]++;
        if (o == 0) wins[s]++;
      end
    end
    for (int o = 0; o < N; o++) begin
      if (!out_valid[o]) begin
        bit bad;
        bad = 1'b0;
        for (int i = 0; i < N; i++) begin
          if (!used[i]) begin
            for (int j = 0; j < imin(was_la ? W : 1, mcnt[i]); j++)
              if (int'(mq[i][j][CELL_W-1:DW]) == o) bad = 1'b1;
          end
        end
        chk(!bad, "R8", "idle output while an offerable cell waits", int'(bad), 0);
      end
      chk(int'(dep_count[o*CNT_W +: CNT_W]) == tally[o], "R11", "departure counter",
          int'(dep_count[o*CNT_W +: CNT_W]), tally[o]);
    end
    for (int i = 0; i < N; i++) begin
      int old_cnt, n;
      logic [CELL_W-1:0] tmp [DEPTH];
      old_cnt = mcnt[i];
      n = 0;
      for (int j = 0; j < mcnt[i]; j++) begin
        if (!gone[i][j]) begin
          tmp[n] = mq[i][j];
          n++;
        end
      end
      for (int j = 0; j < n; j++) mq[i][j] = tmp[j];
      mcnt[i] = n;
      if (a_v[i] && old_cnt == DEPTH) begin
        chk(drop_pulse[i] == 1'b1, "R10", "drop pulse for full arrival", int'(drop_pulse[i]), 1);
        drops++;
      end else begin
        chk(drop_pulse[i] == 1'b0, "R10", "no drop pulse", int'(drop_pulse[i]), 0);
        if (a_v[i]) begin
          mq[i][mcnt[i]] = a_c[i];
          mcnt[i]++;
          accepted++;
        end
      end
      chk(q_full[i] == (mcnt[i] == DEPTH), "R10", "full flag", int'(q_full[i]), int'(mcnt[i] == DEPTH));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    la_en = 1'b0;
    in_valid = '0;
    in_dest = '0;
    in_data = '0;
    for (int i = 0; i < N; i++) begin
      mcnt[i] = 0; tally[i] = 0; seq[i] = 0; wins[i] = 0;
    end
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #2;
    // R1 reset state
    chk(out_valid == '0, "R1", "out_valid after reset", int'(out_valid), 0);
    chk(q_full == '0, "R1", "q_full after reset", int'(q_full), 0);
    chk(drop_pulse == '0, "R1", "drop_pulse after reset", int'(drop_pulse), 0);
    chk(dep_count == '0, "R1", "dep_count after reset", int'(dep_count != '0), 0);

    // R2 latency of a lone cell: input 2 to output 1
    set_in(2, 1);
    tick();
    chk(out_valid == '0, "R2", "no output in capture slot", int'(out_valid), 0);
    tick();
    chk(out_valid == 4'b0010, "R2", "lone cell valid one slot later", int'(out_valid), 2);
    chk(int'(out_src[1*SW +: SW]) == 2, "R2", "lone cell source", int'(out_src[1*SW +: SW]), 2);
    tick();

    // R6 head-of-line case with lookahead off, then the same with lookahead on (R7, R8)
    for (int m = 0; m < 2; m++) begin
      la_en = (m == 1);
      set_in(0, 0); set_in(1, 0);
      tick();
      set_in(1, 1);
      tick();
      repeat (4) tick();
    end

    // R5 sustained two-way contention for output 0, also fills queues (R10)
    la_en = 1'b0;
    for (int i = 0; i < N; i++) wins[i] = 0;
    drops = 0;
    for (int c = 0; c < 200; c++) begin
      set_in(0, 0); set_in(1, 0);
      tick();
    end
    chk(wins[0] >= 10, "R5", "input 0 share of contended slots", wins[0], 10);
    chk(wins[1] >= 10, "R5", "input 1 share of contended slots", wins[1], 10);
    chk(drops > 0, "R10", "drops seen under overload", drops, 1);
    repeat (40) tick();

    // mixed traffic with hot spot, alternating mode (R4, R6, R7, R8, R9)
    for (int c = 0; c < 1200; c++) begin
      la_en = ((c / 150) % 2) == 1;
      for (int i = 0; i < N; i++) begin
        if ($urandom % 100 < 60) set_in(i, ($urandom % 2 == 0) ? 0 : int'($urandom % N));
      end
      tick();
    end

    // R4 drain: everything accepted must leave
    la_en = 1'b1;
    for (int c = 0; c < 200; c++) begin
      int left;
      left = 0;
      for (int i = 0; i < N; i++) left += mcnt[i];
      if (left != 0) tick();
    end
    begin
      int left, sum;
      left = 0;
      sum = 0;
      for (int i = 0; i < N; i++) left += mcnt[i];
      for (int o = 0; o < N; o++) sum += tally[o];
      chk(left == 0, "R4", "cells left after drain", left, 0);
      chk(sum == accepted, "R11", "total departures equal accepted cells", sum, accepted);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule